// File: doc/BRIEF.md
# ADC Conversion Result Serial Port

This block is the read-out port of a 16-bit converter. A conversion sequencer counts a fixed number of master-clock cycles per conversion and, at the end of each one, offers the new result word to a single-word shift register. The word is accepted only if the previous word has been read out completely or the host is not selecting the port. Otherwise the new result is dropped and the unread word stays in place. The result word comes from a stub input that stands in for the filter arithmetic.

An active-low data-ready output tells the host that an unread word is waiting. The host selects the port with an active-low chip select and clocks the word out MSB first with a serial clock. Both host pins are sampled in the master-clock domain. The tri-state data pin is modelled as a data line plus an output enable. The shifter does not move until it has seen a rising serial-clock edge, so a falling edge that comes before that is harmless.

Top module: `adc_result_port`

## Requirements
- R1: A conversion lasts CONV_CYCLES (default 1624) master clocks. The first update attempt happens on the CONV_CYCLES-th rising clock edge after reset is released, and the following ones come every CONV_CYCLES edges after that.
- R2: `ready_n` is 1 during the RDY_LEAD (default 2) clock cycles just before every update attempt, whether or not the attempt loads a word.
- R3: At an update attempt, the result word is loaded if the port is empty or the synchronized chip select is high. If the port holds unread data and is selected, the result is discarded and the held word is kept.
- R4: Loading a word drives `ready_n` to 0.
- R5: Once `cs_n` has been low long enough for the port to take control (synchronizer plus SEL_SETTLE cycles) and a word is held, `sdata_oe` is 1 and `sdata` carries the MSB. While `sdata_oe` is 0, `sdata` is 0.
- R6: A falling serial-clock edge before the first rising edge after selection does not shift. This includes the case where `sclk` was already high when selection began.
- R7: After that rising edge, each falling `sclk` edge presents the next lower bit on `sdata`.
- R8: The falling edge after the LSB drives `sdata_oe` to 0 and `ready_n` to 1, and marks the port empty.
- R9: `sclk` edges seen before the port has taken control are ignored and do not arm the shifter.
- R10: When chip select goes high in the middle of a word, `sdata_oe` goes to 0 and the shifter disarms. The unread word is replaced at the next update attempt.
- R11: While `rst_n` is low, the port is empty, `ready_n` is 1 and `sdata_oe` is 0. The conversion count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| result_word | input | WORD_W | Result of the current conversion (stub source) |
| cs_n | input | 1 | Chip select from the host, active low, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| sdata | output | 1 | Serial data, MSB first |
| sdata_oe | output | 1 | Output enable for the serial data pin |
| ready_n | output | 1 | Data-ready, low while an unread word is held |

## Verification
The assertions assume that `sclk` and `cs_n` each hold every level for at least four master clocks. This lets each level cross the two-flop synchronizer and be seen as a clean edge. They also assume `result_word` is stable at each update edge. The bench keeps every serial-clock phase between four and eight master cycles and always waits eight cycles after a chip-select change before it clocks. It changes `result_word` only well away from the update edges it predicts from its own cycle counter.

// File: rtl/arp_pkg.sv
package arp_pkg;

   // Serial-clock events found in the master-clock domain
   typedef struct packed {
      logic rise;
      logic fall;
   } sclk_evt_t;

endpackage

// File: rtl/arp_sync.sv
module arp_sync #(
   parameter int              W       = 2,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [STAGES-1:0][W-1:0] stg_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("arp_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stg_q <= {STAGES{RST_VAL}};
      else        stg_q <= {stg_q[STAGES-2:0], d_i};
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/arp_conv_seq.sv
module arp_conv_seq #(
   parameter int CONV_CYCLES = 1624,
   parameter int LEAD        = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic update_o,
   output logic lead_o
);

   localparam int            CW      = $clog2(CONV_CYCLES);
   localparam logic [CW-1:0] LAST    = CW'(CONV_CYCLES - 1);
   localparam logic [CW-1:0] LEAD_AT = CW'(CONV_CYCLES - 1 - LEAD);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (cnt_q == LAST)  cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   assign update_o = (cnt_q == LAST);
   assign lead_o   = (cnt_q == LEAD_AT);

endmodule

// File: rtl/arp_select.sv
module arp_select #(
   parameter int SETTLE = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_s,
   input  logic                 sclk_s,
   output logic                 owned_o,
   output arp_pkg::sclk_evt_t   evt_o
);

   localparam int            SW       = $clog2(SETTLE + 1);
   localparam logic [SW-1:0] SETTLE_V = SW'(SETTLE);

   logic [SW-1:0] sel_q;
   logic          sclk_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q  <= '0;
         sclk_q <= 1'b0;
      end else begin
         sclk_q <= sclk_s;
         if (cs_s)                  sel_q <= '0;
         else if (sel_q != SETTLE_V) sel_q <= sel_q + 1'b1;
      end
   end

   assign owned_o    = (sel_q == SETTLE_V) && !cs_s;
   assign evt_o.rise = sclk_s && !sclk_q;
   assign evt_o.fall = !sclk_s && sclk_q;

endmodule

// File: rtl/arp_shifter.sv
module arp_shifter #(
   parameter int W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [W-1:0]       word_i,
   input  logic               owned_i,
   input  arp_pkg::sclk_evt_t evt_i,
   output logic               msb_o,
   output logic               full_o,
   output logic               armed_o,
   output logic               done_o
);

   localparam int            BW       = $clog2(W);
   localparam logic [BW-1:0] LAST_IDX = BW'(W - 1);

   logic [W-1:0]  sh_q;
   logic [BW-1:0] idx_q;
   logic          full_q;
   logic          armed_q;
   logic          last_w;

   assign last_w = (idx_q == LAST_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q    <= '0;
         idx_q   <= '0;
         full_q  <= 1'b0;
         armed_q <= 1'b0;
      end else if (load_i) begin
         sh_q    <= word_i;
         idx_q   <= '0;
         full_q  <= 1'b1;
         armed_q <= 1'b0;
      end else if (!owned_i || !full_q) begin
         armed_q <= 1'b0;
      end else if (armed_q && evt_i.fall) begin
         if (last_w) begin
            full_q  <= 1'b0;
            armed_q <= 1'b0;
         end else begin
            sh_q  <= {sh_q[W-2:0], 1'b0};
            idx_q <= idx_q + 1'b1;
         end
      end else if (evt_i.rise) begin
         armed_q <= 1'b1;
      end
   end

   assign msb_o   = sh_q[W-1];
   assign full_o  = full_q;
   assign armed_o = armed_q;
   assign done_o  = owned_i && full_q && armed_q && evt_i.fall && last_w && !load_i;

endmodule

// File: rtl/adc_result_port.sv
module adc_result_port #(
   parameter int WORD_W      = 16,
   parameter int CONV_CYCLES = 1624,
   parameter int RDY_LEAD    = 2,
   parameter int SYNC_STAGES = 2,
   parameter int SEL_SETTLE  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] result_word,
   input  logic              cs_n,
   input  logic              sclk,
   output logic              sdata,
   output logic              sdata_oe,
   output logic              ready_n
);

   if (WORD_W < 2) begin : g_bad_width
      $error("adc_result_port: WORD_W must be at least 2");
   end
   if (RDY_LEAD < 1 || RDY_LEAD > CONV_CYCLES - 2) begin : g_bad_lead
      $error("adc_result_port: RDY_LEAD out of range");
   end
   if (SEL_SETTLE < 1) begin : g_bad_settle
      $error("adc_result_port: SEL_SETTLE must be at least 1");
   end

   logic [1:0]         pins_s;
   logic               cs_s;
   logic               sclk_s;
   logic               upd_w;
   logic               lead_w;
   logic               load_w;
   logic               done_w;
   logic               full_w;
   logic               armed_w;
   logic               owned_w;
   logic               msb_w;
   logic               fall_w;
   logic               rdy_q;
   arp_pkg::sclk_evt_t evt_w;

   arp_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({cs_n, sclk}),
      .q_o   (pins_s)
   );

   assign cs_s   = pins_s[1];
   assign sclk_s = pins_s[0];

   arp_conv_seq #(.CONV_CYCLES(CONV_CYCLES), .LEAD(RDY_LEAD)) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .update_o (upd_w),
      .lead_o   (lead_w)
   );

   arp_select #(.SETTLE(SEL_SETTLE)) sel_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_s    (cs_s),
      .sclk_s  (sclk_s),
      .owned_o (owned_w),
      .evt_o   (evt_w)
   );

   assign fall_w = evt_w.fall;
   assign load_w = upd_w && (!full_w || cs_s);

   arp_shifter #(.W(WORD_W)) shf_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_w),
      .word_i  (result_word),
      .owned_i (owned_w),
      .evt_i   (evt_w),
      .msb_o   (msb_w),
      .full_o  (full_w),
      .armed_o (armed_w),
      .done_o  (done_w)
   );

   // Data-ready: low on load, high ahead of each update and after the last bit
   always_ff @(posedge clk) begin
      if (!rst_n)      rdy_q <= 1'b1;
      else if (load_w) rdy_q <= 1'b0;
      else if (lead_w) rdy_q <= 1'b1;
      else if (done_w) rdy_q <= 1'b1;
      else if (upd_w)  rdy_q <= !full_w;
   end

   assign ready_n  = rdy_q;
   assign sdata_oe = owned_w && full_w;
   assign sdata    = sdata_oe && msb_w;

endmodule

// File: rtl/adc_result_port_chk.sv
module arp_checker #(
   parameter int RDY_LEAD = 2
) (
   input logic clk,
   input logic rst_n,
   input logic upd,
   input logic lead,
   input logic load,
   input logic done,
   input logic full,
   input logic armed,
   input logic owned,
   input logic cs_s,
   input logic fall,
   input logic msb,
   input logic oe,
   input logic ready_n
);

   assert_update_follows_lead_R1: assert property (@(posedge clk) disable iff (!rst_n)
      lead |-> ##RDY_LEAD upd);

   assert_ready_high_before_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lead |=> ready_n);

   assert_empty_port_accepts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !full) |=> full);

   assert_load_drops_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (!ready_n && full));

   assert_oe_needs_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> (!cs_s && full));

   assert_unarmed_fall_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && !armed && !load) |=> $stable(msb));

   assert_last_fall_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (ready_n && !full && !oe));

   assert_arm_only_when_owned_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(owned));

   assert_deselect_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |-> !oe);

endmodule

bind adc_result_port arp_checker #(.RDY_LEAD(RDY_LEAD)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .upd     (upd_w),
   .lead    (lead_w),
   .load    (load_w),
   .done    (done_w),
   .full    (full_w),
   .armed   (armed_w),
   .owned   (owned_w),
   .cs_s    (cs_s),
   .fall    (fall_w),
   .msb     (msb_w),
   .oe      (sdata_oe),
   .ready_n (ready_n)
);

// File: tb/adc_result_port_tb_top.sv
module adc_result_port_tb_top;

   localparam int W = 16;
   localparam int P = 1624;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] result_word = '0;
   logic         cs_n = 1'b1;
   logic         sclk = 1'b0;
   logic         sdata;
   logic         sdata_oe;
   logic         ready_n;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   always #10 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   adc_result_port #(.WORD_W(W), .CONV_CYCLES(P)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .result_word (result_word),
      .cs_n        (cs_n),
      .sclk        (sclk),
      .sdata       (sdata),
      .sdata_oe    (sdata_oe),
      .ready_n     (ready_n)
   );

   task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_cyc(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   // Expected bit i of a word, counted from the MSB
   function automatic logic bit_at(input logic [W-1:0] w, input int from_msb);
      return w[W-1-from_msb];
   endfunction

   // Select, optionally pre-raise sclk, clock out nbits falling edges, check each bit
   task automatic read_word(input logic [W-1:0] exp, input int nbits,
                            input bit hi_first, input int ph);
      cs_n = 1'b0;
      sclk = hi_first;
      wait_n(8);
      check_eq("R5 oe after select", {31'b0, sdata_oe}, 32'd1);
      check_eq("R5 msb presented", {31'b0, sdata}, {31'b0, bit_at(exp, 0)});
      if (hi_first) begin
         sclk = 1'b0;
         wait_n(ph);
         check_eq("R6 R9 early fall ignored", {31'b0, sdata}, {31'b0, bit_at(exp, 0)});
      end
      sclk = 1'b1;
      wait_n(ph);
      for (int b = 1; b <= nbits; b++) begin
         sclk = 1'b0;
         wait_n(ph);
         if (b < W) begin
            check_eq("R7 next bit", {31'b0, sdata}, {31'b0, bit_at(exp, b)});
         end else begin
            check_eq("R8 oe off after lsb", {31'b0, sdata_oe}, 32'd0);
            check_eq("R8 ready high after lsb", {31'b0, ready_n}, 32'd1);
         end
         sclk = 1'b1;
         wait_n(ph);
      end
      sclk = 1'b0;
      wait_n(ph);
      cs_n = 1'b1;
      wait_n(8);
   endtask

   logic [W-1:0] w_exp;

   initial begin
      void'($urandom(32'h5EED_0A17));
      wait_n(4);
      check_eq("R11 ready in reset", {31'b0, ready_n}, 32'd1);
      check_eq("R11 oe in reset", {31'b0, sdata_oe}, 32'd0);
      result_word = 16'hB3C5;
      rst_n = 1'b1;

      // First load exactly at edge P
      wait_cyc(P - 1);
      check_eq("R1 no load before period", {31'b0, ready_n}, 32'd1);
      wait_cyc(P);
      check_eq("R1 R4 load at period end", {31'b0, ready_n}, 32'd0);
      result_word = 16'h8001;

      // Lead window before the second update; deselected port is replaced
      wait_cyc(2 * P - 3);
      check_eq("R2 ready low before lead", {31'b0, ready_n}, 32'd0);
      wait_cyc(2 * P - 2);
      check_eq("R2 ready high in lead", {31'b0, ready_n}, 32'd1);
      wait_cyc(2 * P - 1);
      check_eq("R2 ready high in lead", {31'b0, ready_n}, 32'd1);
      wait_cyc(2 * P);
      check_eq("R4 ready low after load", {31'b0, ready_n}, 32'd0);
      result_word = 16'h5A3C;
      read_word(16'h8001, W, 1'b1, 6);   // R3 replacement while deselected

      // Selected and full at the update: new result discarded
      wait_cyc(3 * P + 2);
      result_word = 16'hFFFF;
      cs_n = 1'b0;
      wait_cyc(4 * P + 5);
      check_eq("R3 discard keeps ready low", {31'b0, ready_n}, 32'd0);
      read_word(16'h5A3C, W, 1'b0, 5);   // R3 old word kept

      // Deselect mid-word, then replacement at next update
      result_word = 16'h0F96;
      wait_cyc(5 * P + 2);
      read_word(16'h0F96, 5, 1'b0, 5);
      check_eq("R10 oe off after deselect", {31'b0, sdata_oe}, 32'd0);
      check_eq("R10 word still unread", {31'b0, ready_n}, 32'd0);
      result_word = 16'h6D21;
      wait_cyc(6 * P + 2);
      read_word(16'h6D21, W, 1'b0, 5);   // R10 replaced word read from its MSB

      // Constrained random reads
      for (int j = 0; j < 6; j++) begin
         w_exp = W'($urandom);
         result_word = w_exp;
         wait_cyc((7 + j) * P + 2);
         check_eq("R4 ready after random load", {31'b0, ready_n}, 32'd0);
         read_word(w_exp, W, 1'($urandom % 2), 4 + int'($urandom % 5));
      end

      // Reset in the middle of operation
      result_word = 16'hC0DE;
      wait_cyc(13 * P + 2);
      cs_n = 1'b0;
      wait_n(8);
      check_eq("R5 held word driven", {31'b0, sdata_oe}, 32'd1);
      rst_n = 1'b0;
      wait_n(3);
      check_eq("R11 ready after reset", {31'b0, ready_n}, 32'd1);
      check_eq("R11 oe after reset", {31'b0, sdata_oe}, 32'd0);
      cs_n = 1'b1;
      rst_n = 1'b1;
      wait_cyc(P - 1);
      check_eq("R11 R1 count restarted", {31'b0, ready_n}, 32'd1);
      wait_cyc(P);
      check_eq("R11 R1 load after restart", {31'b0, ready_n}, 32'd0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<200000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule